// File: doc/BRIEF.md
# PWM Output Stage With Fault Shutdown

This block sits between the PWM generator pairs and the package pins. Each of its eight pulse-width inputs can be enabled or parked low, and can be inverted on its way out. Four external fault pins are first brought to an active-high form with a per-pin polarity bit. Each can then pass through a persistence filter that needs a programmable number of consecutive asserted clocks. A qualified fault drives every output that has fault handling turned on to its own programmed pin level. It does this in the same cycle, through combinational logic with no register in the path.

Each fault input latches a status bit when it qualifies. While any status bit is set, the fault-enabled outputs stay at their safe levels. Software ends the shutdown by writing ones to the clear address. A clear is refused for an input whose fault is still qualified.

Configuration uses a simple write port with an address, a data word and a write strobe. The fault inputs are taken to be synchronous to `clk`.

Top module: `pwm_outctl`

## Requirements
- R1: An output whose enable bit (address 0) is 0 drives 0, whatever its inversion bit, fault state or safe level.
- R2: An enabled output with no fault shutdown drives its PWM input XOR its inversion bit (address 1), with no clock of delay.
- R3: An output whose fault-handling bit (address 2) is 0 follows R2 while a fault shutdown is in progress.
- R4: An enabled, fault-handling output drives its safe-level bit (address 3) as a pin level, with no inversion applied. This takes effect in the same cycle that any fault becomes qualified.
- R5: Fault polarity bit (address 4) 0 makes a fault input active high. A value of 1 makes it active low.
- R6: With filtering on (address 5, one bit per input) and count N (address 6, 0 to 255), a fault qualifies only once it has been sampled asserted on N consecutive rising edges. A shorter pulse causes no shutdown and no status. With filtering off, or with N = 0, a fault qualifies at once.
- R7: A fault status bit is set on the first rising edge at which its input is qualified. It stays set until it is cleared. While any status bit is set, the R4 shutdown holds.
- R8: Writing to address 7 clears each status bit that has a 1 in the data word. The clear has no effect on a bit whose input is still qualified at that edge.
- R9: After reset all configuration registers are 0, the status is 0 and every output drives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pwm_in | input | 8 | Raw PWM signals from the generators |
| fault_in | input | 4 | External fault pins |
| pwm_out | output | 8 | Pin-level PWM outputs |
| fault_sts | output | 4 | Latched per-input fault status |

## Verification
The hardest states to reach are the ones around the filter boundary. One is a fault pulse that lasts one clock less than the programmed count. Another is a clear written while the fault is still held active. The stimulus drives fault pins on falling edges with an exact count of rising edges. It checks the outputs just after the edge where qualification should, or should not, happen. The clear is issued once while the pin is held and again after it is released. The status is read after each clear.

// File: rtl/pwm_outctl.sv
module pwm_outctl #(
  parameter int N_OUT = 8,
  parameter int N_FLT = 4,
  parameter int FW    = 8,
  localparam int DW   = (N_OUT > FW) ? N_OUT : FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [N_OUT-1:0] pwm_in,
  input  logic [N_FLT-1:0] fault_in,
  output logic [N_OUT-1:0] pwm_out,
  output logic [N_FLT-1:0] fault_sts
);

  logic [N_OUT-1:0] en_q, inv_q, fen_q, safe_q;
  logic [N_FLT-1:0] pol_q, filt_q;
  logic [FW-1:0]    need_q;
  logic [FW-1:0]    cnt_q [N_FLT];
  logic [N_FLT-1:0] asr, qual, clr;
  logic             shut;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      inv_q  <= '0;
      fen_q  <= '0;
      safe_q <= '0;
      pol_q  <= '0;
      filt_q <= '0;
      need_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: en_q   <= cfg_wdata[N_OUT-1:0];
        3'd1: inv_q  <= cfg_wdata[N_OUT-1:0];
        3'd2: fen_q  <= cfg_wdata[N_OUT-1:0];
        3'd3: safe_q <= cfg_wdata[N_OUT-1:0];
        3'd4: pol_q  <= cfg_wdata[N_FLT-1:0];
        3'd5: filt_q <= cfg_wdata[N_FLT-1:0];
        3'd6: need_q <= cfg_wdata[FW-1:0];
        default: ;
      endcase
    end
  end

  assign asr = fault_in ^ pol_q;
  assign clr = (cfg_we && cfg_addr == 3'd7) ? cfg_wdata[N_FLT-1:0] : '0;

  for (genvar f = 0; f < N_FLT; f++) begin : g_flt
    always_ff @(posedge clk) begin
      if (!rst_n || !asr[f])
        cnt_q[f] <= '0;
      else if (cnt_q[f] != '1)
        cnt_q[f] <= cnt_q[f] + 1'b1;
    end

    assign qual[f] = asr[f] && (!filt_q[f] || cnt_q[f] >= need_q);

    always_ff @(posedge clk) begin
      if (!rst_n)
        fault_sts[f] <= 1'b0;
      else if (qual[f])
        fault_sts[f] <= 1'b1;
      else if (clr[f])
        fault_sts[f] <= 1'b0;
    end

    a_r8_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[f] && qual[f]) |=> fault_sts[f]);
    a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_sts[f] && !clr[f]) |=> fault_sts[f]);
    a_r6_set_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_sts[f]) |-> $past(asr[f]));
  end

  assign shut = |qual || |fault_sts;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign pwm_out[o] = en_q[o] && ((shut && fen_q[o]) ? safe_q[o] : (pwm_in[o] ^ inv_q[o]));

    a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[o] |-> !pwm_out[o]);
    a_r4_held_safe: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_sts && en_q[o] && fen_q[o]) |-> (pwm_out[o] == safe_q[o]));
  end

endmodule

// File: tb/pwm_outctl_tb_top.sv
module pwm_outctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] pwm_in = '0;
  logic [3:0] fault_in = '0;
  logic [7:0] pwm_out;
  logic [3:0] fault_sts;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwm_outctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pwm_in(pwm_in), .fault_in(fault_in),
    .pwm_out(pwm_out), .fault_sts(fault_sts)
  );

  localparam logic [31:0] VEC [8] = '{
    32'hFF_00_A5_A5, 32'hFF_FF_A5_5A, 32'h0F_00_FF_0F, 32'hF0_0F_00_00,
    32'h00_FF_00_00, 32'h3C_55_0F_18, 32'hFF_0F_33_3C, 32'h81_01_80_81
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    #160000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    pwm_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", pwm_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 outputs after reset", pwm_out, 8'h00);
    chk("R9 status after reset", {4'h0, fault_sts}, 8'h00);

    for (int v = 0; v < 8; v++) begin
      wr(3'd0, VEC[v][31:24]);
      wr(3'd1, VEC[v][23:16]);
      pwm_in = VEC[v][15:8];
      #1;
      chk("R1/R2 vector", pwm_out, VEC[v][7:0]);
    end

    wr(3'd0, 8'hFF); wr(3'd1, 8'h00); wr(3'd2, 8'h0F); wr(3'd3, 8'h05);
    pwm_in = 8'hAA;
    #1 chk("R2 fault-free baseline", pwm_out, 8'hAA);

    @(negedge clk); fault_in[0] = 1'b1; #1;
    chk("R4 immediate shutdown", pwm_out, 8'hA5);
    chk("R3 masked outputs unaffected", {4'h0, pwm_out[7:4]}, 8'h0A);
    edges(1);
    chk("R7 status set", {4'h0, fault_sts}, 8'h01);
    wr(3'd7, 8'h01);
    chk("R8 clear refused while active", {4'h0, fault_sts}, 8'h01);
    @(negedge clk); fault_in[0] = 1'b0;
    edges(2);
    chk("R7 held safe after pin release", pwm_out, 8'hA5);
    wr(3'd7, 8'h01);
    chk("R8 clear works", {4'h0, fault_sts}, 8'h00);
    chk("R8 outputs restored", pwm_out, 8'hAA);

    wr(3'd1, 8'h0F);
    @(negedge clk); fault_in[2] = 1'b1; #1;
    chk("R4 safe level ignores inversion", pwm_out, 8'hA5);
    wr(3'd0, 8'hF0);
    chk("R1 disabled low under fault", pwm_out, 8'hA0);
    @(negedge clk); fault_in[2] = 1'b0;
    wr(3'd7, 8'h0F); wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
    chk("R8 restored after clear", pwm_out, 8'hAA);

    wr(3'd4, 8'h02);
    fault_in[1] = 1'b1;
    edges(1);
    chk("R5 active-low idle high", pwm_out, 8'hAA);
    @(negedge clk); fault_in[1] = 1'b0; #1;
    chk("R5 active-low fault", pwm_out, 8'hA5);
    @(negedge clk); fault_in[1] = 1'b1;
    wr(3'd7, 8'h02);
    chk("R5 cleared", pwm_out, 8'hAA);

    wr(3'd5, 8'h08); wr(3'd6, 8'd3);
    @(negedge clk); fault_in[3] = 1'b1;
    edges(2);
    @(negedge clk); fault_in[3] = 1'b0;
    edges(2);
    chk("R6 short pulse ignored out", pwm_out, 8'hAA);
    chk("R6 short pulse no status", {4'h0, fault_sts}, 8'h00);
    @(negedge clk); fault_in[3] = 1'b1;
    edges(2);
    chk("R6 not yet qualified", pwm_out, 8'hAA);
    edges(1);
    chk("R6 qualified after N edges", pwm_out, 8'hA5);
    edges(1);
    chk("R6 status after filter", {4'h0, fault_sts}, 8'h08);
    @(negedge clk); fault_in[3] = 1'b0;
    wr(3'd7, 8'h08);
    wr(3'd6, 8'd0);
    @(negedge clk); fault_in[3] = 1'b1; #1;
    chk("R6 count zero immediate", pwm_out, 8'hA5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule